// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt sources into a single request line for a processor. Each source is latched into a status bit, either on a rising edge or on a high level. The choice is fixed per source by a parameter mask. A latched source that is also enabled counts as pending, and the request line rises when any source is pending and both master gates are open.

Software reaches the controller through a plain 32-bit register bus. A read strobe returns data combinationally, and a write strobe commits at the next clock edge. One register gives a direct view of the enable mask. Two alias registers set or clear chosen enable bits without a read-modify-write. Status is cleared by writing ones to an acknowledge register. A vector register returns the index of the highest-priority pending source, so a handler can branch on it at once.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register is selected by the word index `bus_addr_i` (byte offset / 4): 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Reading index 3, 4 or 5 returns zero, and `bus_rdata_o` is zero whenever `bus_rd_i` is low.
- R2: Writing index 2 replaces the enable mask. Bits at or above `NUM_SRC` are dropped and always read as zero.
- R3: Writing a mask to index 4 sets those enable bits and keeps every other enable bit.
- R4: Writing a mask to index 5 clears those enable bits and keeps every other enable bit.
- R5: Writing index 3 clears each status bit whose data bit is 1. Data bits that are 0 leave status untouched.
- R6: For a source whose `EDGE_MASK` bit is 1, a rising input sets its status bit one clock later. The bit holds after the input falls, until it is acknowledged. If an acknowledge and a rising edge reach the same bit in the same cycle, the bit stays set.
- R7: For a source whose `EDGE_MASK` bit is 0, status is set on every clock in which the input is high. An acknowledge while the input is still high therefore leaves the bit set.
- R8: The pending register reads as status AND enable.
- R9: `irq_o` is high exactly when master bit 0 (global enable) and master bit 1 (hardware enable) are both 1 and pending is nonzero. Index 7 reads back those two bits.
- R10: The vector register returns the lowest-numbered pending index, or 0xFFFFFFFF when nothing is pending.
- R11: After reset, status, enable and master are all zero, the vector reads 0xFFFFFFFF and `irq_o` is low.
- R12: Writes to indices 0, 1 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Interrupt source inputs |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with `NUM_SRC` = 6 and `EDGE_MASK` = 0x2A, so edge-captured and level-captured sources alternate. With only six sources, all 64 enable patterns and all 64 acknowledge masks can be swept. Each sweep checks pending, vector priority and the request line against values computed in the bench. The set and clear aliases are swept with derived operand pairs that include bits above the source count. This exposes the dropped upper bits and the retention of untouched bits. Directed sequences on source 0 (level) and source 1 (edge) cover the difference between capture kinds, including the case where an acknowledge and a rising edge land in the same cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    RS_STATUS = 3'd0,
    RS_PEND   = 3'd1,
    RS_ENABLE = 3'd2,
    RS_ACK    = 3'd3,
    RS_SETEN  = 3'd4,
    RS_CLREN  = 3'd5,
    RS_VECTOR = 3'd6,
    RS_MASTER = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic hw_en;
    logic glob_en;
  } master_t;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    if (EDGE_MASK[gi]) begin : g_edge
      logic prev_q, stat_q, stat_d, rise, stat_ce;

      assign rise    = src_i[gi] & ~prev_q;
      assign stat_ce = ack_i[gi] | rise;

      always_comb begin
        stat_d = (stat_q & ~ack_i[gi]) | rise;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else if (prev_q != src_i[gi]) begin
          prev_q <= src_i[gi];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= 1'b0;
        end else if (stat_ce) begin
          stat_q <= stat_d;
        end
      end

      assign status_o[gi] = stat_q;

      // R6: a latched edge survives while no acknowledge arrives
      a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !ack_i[gi]) |=> stat_q);
      // R6: an edge coinciding with an acknowledge wins
      a_r6_ack_race: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && ack_i[gi]) |=> stat_q);
      // R5: acknowledge without a fresh edge clears the bit
      a_r5_edge_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[gi] && !rise) |=> !stat_q);
    end else begin : g_level
      logic stat_q, stat_d, stat_ce;

      assign stat_ce = ack_i[gi] | src_i[gi];

      always_comb begin
        stat_d = (stat_q & ~ack_i[gi]) | src_i[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q <= 1'b0;
        end else if (stat_ce) begin
          stat_q <= stat_d;
        end
      end

      assign status_o[gi] = stat_q;

      // R7: a high level always leaves the bit set
      a_r7_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[gi] |=> stat_q);
      // R5: acknowledge with the level low clears the bit
      a_r5_level_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i[gi] && !src_i[gi]) |=> !stat_q);
    end
  end
endmodule

// File: rtl/vic_enable.sv
module vic_enable
  import vic_pkg::*;
#(
  parameter logic [REG_W-1:0] ACT_MASK = 32'h0000_00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             we_plain_i,
  input  logic             we_set_i,
  input  logic             we_clr_i,
  input  logic             we_master_i,
  output logic [REG_W-1:0] enable_o,
  output master_t          master_o
);
  logic [REG_W-1:0] en_q, en_d;
  logic             en_ce;
  master_t          mst_q, mst_d;

  assign en_ce = we_plain_i | we_set_i | we_clr_i;

  always_comb begin
    en_d = en_q;
    if (we_plain_i) begin
      en_d = wdata_i & ACT_MASK;
    end else if (we_set_i) begin
      en_d = en_q | (wdata_i & ACT_MASK);
    end else if (we_clr_i) begin
      en_d = en_q & ~wdata_i;
    end
  end

  always_comb begin
    mst_d = master_t'(wdata_i[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q <= '0;
    end else if (we_master_i) begin
      mst_q <= mst_d;
    end
  end

  assign enable_o = en_q;
  assign master_o = mst_q;

  // R3: set alias keeps every previous bit
  a_r3_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    we_set_i |=> ((enable_o & $past(enable_o)) == $past(enable_o)));
  // R3: set alias adds the requested active bits
  a_r3_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    we_set_i |=> ((enable_o & $past(wdata_i & ACT_MASK)) == $past(wdata_i & ACT_MASK)));
  // R4: clear alias drops the requested bits
  a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr_i |=> ((enable_o & $past(wdata_i)) == '0));
  // R4: clear alias never adds a bit
  a_r4_clr_no_add: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr_i |=> ((enable_o & ~$past(enable_o)) == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [REG_W-1:0]   vec_o,
  output logic               any_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

  assign any_o = |pend_i;
  assign vec_o = any_o ? {{(REG_W-IDX_W){1'b0}}, idx} : '1;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int          NUM_SRC   = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_00F0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [4:2]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam logic [REG_W-1:0] ACT_MASK =
    (NUM_SRC >= REG_W) ? {REG_W{1'b1}} : ((REG_W'(1) << NUM_SRC) - REG_W'(1));

  reg_sel_e         sel;
  logic             we_ack, we_plain, we_set, we_clr, we_master;
  logic [NUM_SRC-1:0] ack_n, stat_n, pend_n;
  logic [REG_W-1:0] stat_w, enable_w, pend_w, vec_w;
  logic             any_pend;
  master_t          master_w;

  assign sel       = reg_sel_e'(bus_addr_i);
  assign we_ack    = bus_wr_i & (sel == RS_ACK);
  assign we_plain  = bus_wr_i & (sel == RS_ENABLE);
  assign we_set    = bus_wr_i & (sel == RS_SETEN);
  assign we_clr    = bus_wr_i & (sel == RS_CLREN);
  assign we_master = bus_wr_i & (sel == RS_MASTER);

  assign ack_n = we_ack ? bus_wdata_i[NUM_SRC-1:0] : '0;

  vic_capture #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (irq_src_i),
    .ack_i    (ack_n),
    .status_o (stat_n)
  );

  vic_enable #(
    .ACT_MASK (ACT_MASK)
  ) u_enable (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdata_i     (bus_wdata_i),
    .we_plain_i  (we_plain),
    .we_set_i    (we_set),
    .we_clr_i    (we_clr),
    .we_master_i (we_master),
    .enable_o    (enable_w),
    .master_o    (master_w)
  );

  always_comb begin
    stat_w = '0;
    stat_w[NUM_SRC-1:0] = stat_n;
  end

  assign pend_n = stat_n & enable_w[NUM_SRC-1:0];

  always_comb begin
    pend_w = '0;
    pend_w[NUM_SRC-1:0] = pend_n;
  end

  vic_prio #(
    .NUM_SRC (NUM_SRC)
  ) u_prio (
    .pend_i (pend_n),
    .vec_o  (vec_w),
    .any_o  (any_pend)
  );

  assign irq_o = master_w.glob_en & master_w.hw_en & any_pend;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      unique case (sel)
        RS_STATUS: bus_rdata_o = stat_w;
        RS_PEND:   bus_rdata_o = pend_w;
        RS_ENABLE: bus_rdata_o = enable_w;
        RS_VECTOR: bus_rdata_o = vec_w;
        RS_MASTER: bus_rdata_o = {{(REG_W-2){1'b0}}, master_w};
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  // R9: request only with both gates open and something pending
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (master_w.glob_en && master_w.hw_en && (stat_w & enable_w) != '0));
  // R10: a reported vector names a pending, enabled source
  a_r10_vec_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_w != '1) |-> (stat_w[vec_w[IDX_W-1:0]] && enable_w[vec_w[IDX_W-1:0]]));
  // R10: nothing below the reported vector is pending
  a_r10_vec_low: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_w != '1) |-> ((stat_w & enable_w & ((REG_W'(1) << vec_w[IDX_W-1:0]) - REG_W'(1))) == '0));
  // R2: enable bits outside the active sources stay clear
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    we_plain |=> ((enable_w & ~ACT_MASK) == '0));
  // R12: a write to a read-only index leaves enable untouched
  a_r12_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && (sel == RS_STATUS || sel == RS_PEND || sel == RS_VECTOR)) |=> $stable(enable_w));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int          NSRC  = 6;
  localparam logic [31:0] EMASK = 32'h0000_002A;
  localparam logic [31:0] ALL   = 32'h0000_003F;

  logic              clk;
  logic              rst_n;
  logic [NSRC-1:0]   irq_in;
  logic              bus_rd, bus_wr;
  logic [4:2]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq;
  int                checks = 0;
  int                errors = 0;
  logic              done = 1'b0;

  irq_vector_ctrl #(.NUM_SRC(NSRC), .EDGE_MASK(EMASK)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_in), .bus_rd_i(bus_rd),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic drive(input logic [NSRC-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic pulse_all();
    drive('1);
    drive('0);
  endtask

  function automatic logic [31:0] lowest(input logic [31:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = NSRC - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state, R1 write-only indices read zero
    rd(3'd0, d); check("R11 status", d, 0);
    rd(3'd1, d); check("R11 pending", d, 0);
    rd(3'd2, d); check("R11 enable", d, 0);
    rd(3'd6, d); check("R11 vector", d, 32'hFFFF_FFFF);
    rd(3'd7, d); check("R11 master", d, 0);
    check("R11 irq", {31'd0, irq}, 0);
    for (int a = 3; a <= 5; a++) begin
      rd(a[2:0], d); check("R1 write-only index", d, 0);
    end
    bus_addr = 3'd2; #1 check("R1 no strobe", bus_rdata, 0);

    // R9 master read back
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd7, d); check("R9 master bits", d, 3);

    // R6 R7 all sources latched by a pulse
    pulse_all();
    rd(3'd0, d); check("R6 R7 pulse latched", d, ALL);

    // R2 R8 R10 R9 sweep of enable patterns
    for (int e = 0; e < 64; e++) begin
      wr(3'd2, 32'(e) | 32'hFFFF_FFC0);
      rd(3'd2, d); check("R2 enable upper dropped", d, 32'(e));
      rd(3'd1, d); check("R8 pending", d, 32'(e));
      rd(3'd6, d); check("R10 vector", d, lowest(32'(e)));
      check("R9 irq", {31'd0, irq}, {31'd0, e != 0});
    end

    // R3 R4 alias sweep
    for (int a = 0; a < 64; a++) begin
      logic [31:0] b, c, exp;
      b = 32'((a * 7 + 3) & 63) | 32'hFF00_0040;
      c = 32'((a * 11 + 5) & 63);
      wr(3'd2, 32'(a));
      wr(3'd4, b);
      exp = (32'(a) | b) & ALL;
      rd(3'd2, d); check("R3 set-enable", d, exp);
      wr(3'd5, c);
      exp = exp & ~c;
      rd(3'd2, d); check("R4 clear-enable", d, exp);
    end

    // R9 master gating
    wr(3'd2, ALL);
    for (int m = 0; m < 4; m++) begin
      wr(3'd7, 32'(m));
      rd(3'd7, d); check("R9 master read", d, 32'(m));
      check("R9 irq gate", {31'd0, irq}, {31'd0, m == 3});
    end

    // R5 acknowledge sweep
    for (int k = 0; k < 64; k++) begin
      pulse_all();
      wr(3'd3, 32'(k));
      rd(3'd0, d); check("R5 ack mask", d, ALL & ~32'(k));
    end
    pulse_all();
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R5 ack all", d, 0);

    // R7 level source 0
    drive(6'h01);
    wr(3'd3, 32'h1);
    rd(3'd0, d); check("R7 ack while high", d, 32'h1);
    drive(6'h00);
    wr(3'd3, 32'h1);
    rd(3'd0, d); check("R7 ack after low", d, 0);

    // R6 edge source 1
    drive(6'h02);
    drive(6'h00);
    @(negedge clk);
    rd(3'd0, d); check("R6 edge held", d, 32'h2);
    wr(3'd3, 32'h2);
    rd(3'd0, d); check("R6 edge acked", d, 0);
    drive(6'h02);
    wr(3'd3, 32'h2);
    repeat (2) @(negedge clk);
    rd(3'd0, d); check("R6 no new edge", d, 0);
    drive(6'h00);
    drive(6'h02);
    drive(6'h00);
    @(negedge clk);
    irq_in = 6'h02; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd0, d); check("R6 edge beats ack", d, 32'h2);
    drive(6'h00);

    // R12 writes to read-only indices
    wr(3'd3, 32'hFFFF_FFFF);
    pulse_all();
    wr(3'd2, 32'h15);
    wr(3'd0, 0); wr(3'd1, 0); wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R12 status kept", d, ALL);
    rd(3'd2, d); check("R12 enable kept", d, 32'h15);
    rd(3'd6, d); check("R12 vector", d, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule